// File: doc/BRIEF.md
# Ring Presence Qualifier

This block sits behind a ring frequency discriminator. The discriminator issues one result per measured ring period: a strobe (`done_i`) together with a validity level (`valid_i`). From these results the block drives an alert enable, for example the enable of a tone or melody generator.

The block does not alert at once. First, valid results must arrive with no break for a qualification window of `QUAL_TICKS` clock cycles. A result counts as missing when no strobe arrives for `GAP_TICKS` cycles. An invalid result or a missing result during this window sends the block back to idle, and the window then starts again from the next valid result.

Once the window completes, the block stops filtering. The alert then follows each new result one cycle after its strobe: valid turns it on, invalid turns it off, and a gap with no strobes turns it off. This tracking mode lasts until reset or until `off_hook_i` is asserted. Off-hook overrides every other input and returns the block to idle.

Top module: `ring_presence_qualifier`

## Requirements
- R1: While `rst_ni` is low, `alert_o` is 0 without waiting for a clock edge, and the block is idle after reset is released.
- R2: When every result is valid and the strobes are at most `GAP_TICKS` cycles apart, `alert_o` rises exactly `QUAL_TICKS` cycles after the clock edge that sampled the first valid result. It is still 0 one cycle earlier.
- R3: An invalid result during qualification abandons it. `alert_o` stays 0 and the next valid result restarts the full `QUAL_TICKS` window.
- R4: During qualification, if no strobe arrives within `GAP_TICKS` cycles of the previous one, qualification is abandoned. A ring whose results are spaced `GAP_TICKS+1` apart therefore never raises `alert_o`.
- R5: In tracking mode, `alert_o` is 1 in the cycle after a valid strobe and 0 in the cycle after an invalid strobe.
- R6: In tracking mode, `GAP_TICKS` cycles without a strobe drop `alert_o` to 0. Tracking continues, so the next valid strobe raises `alert_o` in the following cycle with no new qualification.
- R7: `off_hook_i` overrides all other inputs. A high sample clears the block to idle with `alert_o` 0 in the next cycle, and results are ignored while it stays high. After it is released, a full new qualification is needed.
- R8: `valid_i` has no effect in any cycle where `done_i` is low.
- R9: An invalid result sampled at the same edge where the qualification window would complete wins: `alert_o` stays 0, and qualification restarts from the next valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; both timers count its cycles |
| rst_ni | input | 1 | Asynchronous reset, active low |
| off_hook_i | input | 1 | Handset off hook; clears the block to idle |
| done_i | input | 1 | One-cycle strobe marking a new discriminator result |
| valid_i | input | 1 | Result level: 1 = in-band ring period, 0 = out of band |
| alert_o | output | 1 | Alert enable, high in tracking mode while the latest result is valid |

## Verification
The bench sweeps the strobe spacing from every cycle up to exactly `GAP_TICKS`, and then one cycle beyond it. A gap check that is off by one would either lose rings at the legal limit or qualify a ring that has stopped.

It places a single invalid result at every position in the window, including the completing edge. A design that does not clear the presence timer, or that lets completion beat the invalid result, would alert too early or at the wrong moment.

In tracking mode it mixes result patterns with idle cycles that carry a junk validity level. This catches an output that samples `valid_i` without its strobe, and a design that wrongly requalifies after a gap.

Off-hook is applied in each state and together with a valid strobe. Reset is applied between clock edges. A design that gives priority to the strobe, or that keeps its qualified state, would raise the alert early.

// File: rtl/rpq_pkg.sv
package rpq_pkg;
  typedef enum logic [1:0] {
    RPQ_IDLE  = 2'd0,
    RPQ_QUAL  = 2'd1,
    RPQ_TRACK = 2'd2
  } rpq_state_e;
endpackage

// File: rtl/rpq_presence_timer.sv
module rpq_presence_timer #(
  parameter int unsigned LIMIT = 4688
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic full_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign full_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (!full_o) begin
      cnt_q <= cnt_q + W'(1);
    end
  end
endmodule

// File: rtl/rpq_gap_watch.sv
module rpq_gap_watch #(
  parameter int unsigned LIMIT = 3125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic seen_i,
  output logic expire_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;
  logic         at_last;

  assign at_last  = (cnt_q == LAST);
  // a strobe in the limit cycle still counts as on time
  assign expire_o = arm_i && !seen_i && at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!arm_i || seen_i) begin
      cnt_q <= '0;
    end else if (!at_last) begin
      cnt_q <= cnt_q + W'(1);
    end
  end
endmodule

// File: rtl/rpq_ctrl.sv
module rpq_ctrl
  import rpq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       off_hook_i,
  input  logic       done_i,
  input  logic       valid_i,
  input  logic       qual_full_i,
  input  logic       gap_expire_i,
  output rpq_state_e state_o,
  output logic       alert_o
);
  rpq_state_e state_q, state_d;
  logic       latest_q, latest_d;
  logic       good_res, bad_res;

  assign good_res = done_i && valid_i;
  assign bad_res  = done_i && !valid_i;

  always_comb begin
    state_d  = state_q;
    latest_d = latest_q;
    if (off_hook_i) begin
      state_d  = RPQ_IDLE;
      latest_d = 1'b0;
    end else begin
      unique case (state_q)
        RPQ_IDLE: begin
          latest_d = 1'b0;
          if (good_res) state_d = RPQ_QUAL;
        end
        RPQ_QUAL: begin
          // invalid or missing result beats window completion
          if (bad_res || gap_expire_i) begin
            state_d = RPQ_IDLE;
          end else if (qual_full_i) begin
            state_d  = RPQ_TRACK;
            latest_d = 1'b1;
          end
        end
        RPQ_TRACK: begin
          if (done_i)            latest_d = valid_i;
          else if (gap_expire_i) latest_d = 1'b0;
        end
        default: begin
          state_d  = RPQ_IDLE;
          latest_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= RPQ_IDLE;
      latest_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      latest_q <= latest_d;
    end
  end

  assign state_o = state_q;
  assign alert_o = (state_q == RPQ_TRACK) && latest_q;
endmodule

// File: rtl/ring_presence_qualifier.sv
module ring_presence_qualifier
  import rpq_pkg::*;
#(
  parameter int unsigned QUAL_TICKS = 4688,
  parameter int unsigned GAP_TICKS  = 3125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic off_hook_i,
  input  logic done_i,
  input  logic valid_i,
  output logic alert_o
);
  rpq_state_e state;
  logic       qual_full;
  logic       gap_expire;

  rpq_presence_timer #(.LIMIT(QUAL_TICKS)) u_presence (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state == RPQ_QUAL),
    .full_o (qual_full)
  );

  rpq_gap_watch #(.LIMIT(GAP_TICKS)) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (state != RPQ_IDLE),
    .seen_i   (done_i),
    .expire_o (gap_expire)
  );

  rpq_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .off_hook_i   (off_hook_i),
    .done_i       (done_i),
    .valid_i      (valid_i),
    .qual_full_i  (qual_full),
    .gap_expire_i (gap_expire),
    .state_o      (state),
    .alert_o      (alert_o)
  );
endmodule

// File: rtl/rpq_checker.sv
module rpq_checker
  import rpq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       off_hook_i,
  input logic       done_i,
  input logic       valid_i,
  input logic       alert_o,
  input rpq_state_e state_i,
  input logic       qual_full_i,
  input logic       gap_expire_i
);
  p_offhook_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_hook_i |=> (!alert_o && state_i == RPQ_IDLE));

  p_invalid_drops_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !valid_i) |=> !alert_o);

  p_valid_raises_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == RPQ_TRACK && done_i && valid_i && !off_hook_i) |=> alert_o);

  p_gap_drops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == RPQ_TRACK && gap_expire_i && !off_hook_i) |=> (!alert_o && state_i == RPQ_TRACK));

  p_gap_abandons_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == RPQ_QUAL && gap_expire_i) |=> (state_i == RPQ_IDLE));

  p_window_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == RPQ_QUAL && qual_full_i && !off_hook_i && !gap_expire_i && !(done_i && !valid_i))
    |=> alert_o);

  p_no_strobe_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == RPQ_TRACK && !done_i && !gap_expire_i && !off_hook_i) |=> $stable(alert_o));

  p_alert_only_tracking_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |-> (state_i == RPQ_TRACK));
endmodule

bind ring_presence_qualifier rpq_checker u_rpq_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .off_hook_i   (off_hook_i),
  .done_i       (done_i),
  .valid_i      (valid_i),
  .alert_o      (alert_o),
  .state_i      (state),
  .qual_full_i  (qual_full),
  .gap_expire_i (gap_expire)
);

// File: tb/tb_ring_presence_qualifier.sv
module tb_ring_presence_qualifier;
  localparam int Q = 20;
  localparam int G = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic off_hook_i = 1'b0;
  logic done_i = 1'b0;
  logic valid_i = 1'b0;
  logic alert_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  ring_presence_qualifier #(.QUAL_TICKS(Q), .GAP_TICKS(G)) dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .off_hook_i (off_hook_i),
    .done_i     (done_i),
    .valid_i    (valid_i),
    .alert_o    (alert_o)
  );

  always #4 clk_i = ~clk_i;

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: alert_o=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // drive, take one edge, sample 1 ns after it
  task automatic step(input logic d, input logic v, input logic oh);
    done_i = d; valid_i = v; off_hook_i = oh;
    @(posedge clk_i);
    #1;
  endtask

  task automatic clear_hook();
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic qualify();
    for (int n = 0; n <= Q; n++) step(1'b1, 1'b1, 1'b0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] pat;
    #1;
    check("R1 async reset", alert_o, 1'b0);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    check("R1 idle after reset", alert_o, 1'b0);

    // R2: spacing sweep up to the gap limit
    for (int s = 1; s <= G; s++) begin
      for (int n = 0; n <= Q + 2; n++) begin
        step((n % s) == 0, 1'b1, 1'b0);
        if (n == Q - 1) check("R2 before window end", alert_o, 1'b0);
        if (n == Q)     check("R2 at window end", alert_o, 1'b1);
      end
      step(1'b0, 1'b0, 1'b1);
      check("R7 off-hook clears", alert_o, 1'b0);
      step(1'b0, 1'b0, 1'b0);
    end

    // R4: spacing one beyond the limit never qualifies
    for (int n = 0; n <= 4 * Q; n++) begin
      step((n % (G + 1)) == 0, 1'b1, 1'b0);
      check("R4 sparse ring", alert_o, 1'b0);
    end
    clear_hook();

    // R3/R9: one invalid result at every window position
    for (int m = 1; m <= Q; m++) begin
      for (int n = 0; n <= m + Q + 1; n++) begin
        step(1'b1, n != m, 1'b0);
        if (n == m)         check(m == Q ? "R9 invalid at completion" : "R3 invalid in window", alert_o, 1'b0);
        if (n == m + Q)     check("R3 restart not early", alert_o, 1'b0);
        if (n == m + Q + 1) check("R3 restart completes", alert_o, 1'b1);
      end
      clear_hook();
    end

    // R5/R8: tracking follows results, junk level between strobes
    qualify();
    pat = 16'hB4D2;
    for (int i = 0; i < 16; i++) begin
      step(1'b1, pat[i], 1'b0);
      check("R5 tracks result", alert_o, pat[i]);
      step(1'b0, ~pat[i], 1'b0);
      check("R8 level ignored without strobe", alert_o, pat[i]);
    end
    clear_hook();

    // R6: gap in tracking drops, next valid raises without requal
    qualify();
    for (int k = 1; k <= G; k++) begin
      step(1'b0, 1'b1, 1'b0);
      check("R6 gap timing", alert_o, k < G);
    end
    step(1'b0, 1'b1, 1'b0);
    check("R6 stays low", alert_o, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    check("R6 resumes without requal", alert_o, 1'b1);

    // R7: off-hook with a valid strobe in tracking
    step(1'b1, 1'b1, 1'b1);
    check("R7 off-hook beats strobe", alert_o, 1'b0);
    for (int n = 0; n < Q + 5; n++) step(1'b1, 1'b1, 1'b1);
    check("R7 held off-hook ignores results", alert_o, 1'b0);
    for (int n = 0; n <= Q; n++) begin
      step(1'b1, 1'b1, 1'b0);
      if (n == Q - 1) check("R7 requal needed", alert_o, 1'b0);
      if (n == Q)     check("R7 requal completes", alert_o, 1'b1);
    end
    clear_hook();
    for (int n = 0; n <= Q + 3; n++) begin
      step(1'b1, 1'b1, n == 5);
      if (n == Q) check("R7 off-hook mid window", alert_o, 1'b0);
    end
    clear_hook();

    // R1: asynchronous reset in tracking
    qualify();
    check("R1 pre-reset tracking", alert_o, 1'b1);
    #2 rst_ni = 1'b0;
    #1 check("R1 async clear", alert_o, 1'b0);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    step(1'b1, 1'b1, 1'b0);
    check("R1 no stale qualification", alert_o, 1'b0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule